// File: doc/BRIEF.md
# Masked Channel Packing Router

This block gathers a chosen subset of its input lanes and packs them, in ascending lane order, onto a contiguous window of output lanes. A channel mask picks the active inputs and a slot number picks the window. With k active inputs, slot s places them on output lanes s*k up to s*k+k-1. Cycling the slot across successive cycles therefore spreads a narrow selection over every output lane in turn. This suits the case where any output lane is as good as any other, for example when each output feeds its own memory.

Each output lane is a tree of 2-way multiplexers that is log2(lane count) levels deep, and every level is registered. A per-lane write enable marks the lanes that carry routed data. The write enables arrive one cycle before the data they qualify, so they can drive memory write ports that need the enable a cycle early. The mask and the slot may change on every clock. There is no reset: the pipeline fills from its inputs.

Top module: `banyan_router`

## Requirements
- R1: With k bits set in the mask (k a power of two, 1 <= k <= NP) and slot s < NP/k, the selected input lanes, taken from lowest to highest index, appear on output lanes s*k, s*k+1, ... s*k+k-1. Lane n occupies bits n*DW+DW-1 down to n*DW of the data buses.
- R2: The data permutation for a given mask and slot appears on data_o exactly RL+1 clock cycles after those control values are sampled.
- R3: we_o reflects a given mask and slot exactly RL cycles after they are sampled. It has exactly the k bits of the window set and all other bits clear.
- R4: Every data_o lane whose write enable was clear in the previous cycle reads zero.
- R5: The mask, the slot and the data may change on every cycle. Each cycle's control values route that same cycle's data, with no interference between neighbouring cycles.
- R6: A mask with all NP bits set and slot 0 passes every input lane straight through to the output lane with the same index.
- R7: A mask with a single bit set routes that input lane to output lane s for every slot s from 0 to NP-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| slot_i | input | RL | Time slot that selects the output window |
| chan_mask_i | input | NP | Active input lanes |
| data_i | input | DW*NP | Input lanes, lane n at bits n*DW upward |
| we_o | output | NP | Output lanes that carry routed data (write enables) |
| data_o | output | DW*NP | Packed output lanes |

## Verification
The assertions assume that the mask has a power-of-two number of set bits, or none. They also assume that the slot keeps the window within the lanes. The contiguity and distinct-source checks apply only under that condition. They are disabled until the pipeline has filled from its power-up contents. The stimulus walks every legal mask with every legal slot on back-to-back cycles and uses fresh random data. Mask values with three set bits and an all-clear flush are applied, but their outputs are not compared, because those outputs are unspecified.

// File: rtl/banyan_router.sv
module banyan_router #(
  parameter int DW = 16,
  parameter int NP = 8,
  parameter int RL = 3
) (
  input  logic              clk,
  input  logic [RL-1:0]     slot_i,
  input  logic [NP-1:0]     chan_mask_i,
  input  logic [DW*NP-1:0]  data_i,
  output logic [NP-1:0]     we_o,
  output logic [DW*NP-1:0]  data_o
);
  localparam int FILL = RL + 1;

  logic [RL-1:0] src_c [NP];
  logic [NP-1:0] val_c;
  logic [DW-1:0] in_q [NP];
  logic [DW-1:0] lvl  [RL][NP][NP];
  logic [RL-1:0] src_q [RL][NP];
  logic [NP-1:0] val_q [RL+1];
  logic [7:0]    fill = '0;
  logic          warm;

  always_comb begin
    int k;
    int base;
    int rank;
    k = 0;
    for (int i = 0; i < NP; i++) k += int'(chan_mask_i[i]);
    base = int'(slot_i) * k;
    for (int j = 0; j < NP; j++) begin
      src_c[j] = '0;
      val_c[j] = 1'b0;
      rank = 0;
      for (int i = 0; i < NP; i++) begin
        if (chan_mask_i[i]) begin
          if (rank == j - base) begin
            src_c[j] = RL'(i);
            val_c[j] = 1'b1;
          end
          rank++;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++) in_q[i] <= data_i[i*DW +: DW];
    for (int j = 0; j < NP; j++) src_q[0][j] <= src_c[j];
    for (int l = 1; l < RL; l++)
      for (int j = 0; j < NP; j++) src_q[l][j] <= src_q[l-1][j];
    val_q[0] <= val_c;
    for (int l = 1; l <= RL; l++) val_q[l] <= val_q[l-1];
    for (int l = 0; l < RL; l++)
      for (int j = 0; j < NP; j++)
        for (int e = 0; e < NP; e++) begin
          if (e < (NP >> (l + 1))) begin
            if (l == 0)
              lvl[l][j][e] <= src_q[l][j][l] ? in_q[(2*e+1) % NP] : in_q[(2*e) % NP];
            else
              lvl[l][j][e] <= src_q[l][j][l] ? lvl[(l == 0) ? 0 : l-1][j][(2*e+1) % NP]
                                             : lvl[(l == 0) ? 0 : l-1][j][(2*e) % NP];
          end else begin
            lvl[l][j][e] <= '0;
          end
        end
    if (fill != 8'(FILL)) fill <= fill + 8'd1;
  end

  assign warm = (fill == 8'(FILL));
  assign we_o = val_q[RL-1];

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_lane
      assign data_o[g*DW +: DW] = val_q[RL][g] ? lvl[RL-1][g][0] : '0;

      p_src_active_r1: assert property (@(posedge clk) disable iff (!warm)
        val_c[g] |-> chan_mask_i[src_c[g]]);

      p_idle_zero_r4: assert property (@(posedge clk) disable iff (!warm)
        !$past(we_o[g]) |-> (data_o[g*DW +: DW] == '0));
    end
  endgenerate

  logic mask_legal;
  assign mask_legal = ($countones(chan_mask_i) != 0) &&
                      (($countones(chan_mask_i) & ($countones(chan_mask_i) - 1)) == 0) &&
                      (int'(slot_i) * $countones(chan_mask_i) < NP);

  p_contig_r1: assert property (@(posedge clk) disable iff (!warm)
    mask_legal |-> $onehot(val_c & ~(val_c << 1)));

  p_distinct_r3: assert property (@(posedge clk) disable iff (!warm)
    mask_legal |-> ($countones(val_c) == $countones(chan_mask_i)));
endmodule

// File: tb/banyan_router_tb_top.sv
module banyan_router_tb_top;
  localparam int DW = 16;
  localparam int NP = 8;
  localparam int RL = 3;
  localparam int MAXE = 512;
  localparam int NV = 6;
  // {mask, slot, expected write enables}
  localparam logic [18:0] VEC [NV] = '{
    {8'hFF, 3'd0, 8'hFF},
    {8'h01, 3'd5, 8'h20},
    {8'h81, 3'd2, 8'h30},
    {8'h0F, 3'd1, 8'hF0},
    {8'h5A, 3'd0, 8'h0F},
    {8'h24, 3'd3, 8'hC0}
  };

  logic clk = 1'b0;
  logic [RL-1:0] slot_i = '0;
  logic [NP-1:0] chan_mask_i = '0;
  logic [DW*NP-1:0] data_i = '0;
  logic [NP-1:0] we_o;
  logic [DW*NP-1:0] data_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NP-1:0]    em [MAXE];
  logic [RL-1:0]    et [MAXE];
  logic [DW*NP-1:0] ed [MAXE];
  bit               ek [MAXE];
  logic [NP-1:0]    ew [MAXE];
  bit               ew_ok [MAXE];
  int ne = 0;

  always #2 clk = ~clk;

  banyan_router #(.DW(DW), .NP(NP), .RL(RL)) dut_i (
    .clk(clk), .slot_i(slot_i), .chan_mask_i(chan_mask_i),
    .data_i(data_i), .we_o(we_o), .data_o(data_o));

  function automatic int cnt(input logic [NP-1:0] m);
    int c;
    c = 0;
    for (int i = 0; i < NP; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [NP-1:0] model_we(input logic [NP-1:0] m, input logic [RL-1:0] t);
    logic [NP-1:0] r;
    int pos;
    r = '0;
    pos = int'(t) * cnt(m);
    for (int i = 0; i < NP; i++)
      if (m[i]) begin r[pos % NP] = 1'b1; pos++; end
    return r;
  endfunction

  function automatic logic [DW*NP-1:0] model_data(input logic [NP-1:0] m, input logic [RL-1:0] t,
                                                  input logic [DW*NP-1:0] d);
    logic [DW*NP-1:0] r;
    int pos;
    r = '0;
    pos = int'(t) * cnt(m);
    for (int i = 0; i < NP; i++)
      if (m[i]) begin r[(pos % NP)*DW +: DW] = d[i*DW +: DW]; pos++; end
    return r;
  endfunction

  function automatic string tag_of(input logic [NP-1:0] m);
    if (cnt(m) == NP) return "R6";
    if (cnt(m) == 1) return "R7";
    return "R1";
  endfunction

  function automatic logic [DW*NP-1:0] rnd_data();
    logic [DW*NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  task automatic add(input logic [NP-1:0] m, input logic [RL-1:0] t, input bit chk,
                     input logic [NP-1:0] w, input bit wok);
    em[ne] = m; et[ne] = t; ed[ne] = rnd_data(); ek[ne] = chk;
    ew[ne] = w; ew_ok[ne] = wok;
    ne++;
  endtask

  initial begin
    int k;
    for (int v = 0; v < NV; v++)
      add(VEC[v][18:11], VEC[v][10:8], 1'b1, VEC[v][7:0], 1'b1);
    for (int m = 1; m < (1 << NP); m++) begin
      k = cnt(NP'(m));
      if ((k & (k - 1)) == 0)
        for (int t = 0; t < NP / k; t++) add(NP'(m), RL'(t), 1'b1, '0, 1'b0);
    end
    add(8'h07, 3'd1, 1'b0, '0, 1'b0);
    add(8'hE0, 3'd0, 1'b0, '0, 1'b0);
    for (int f = 0; f < RL + 3; f++) add('0, '0, 1'b0, '0, 1'b0);

    for (int n = 0; n < ne + RL + 2; n++) begin
      @(negedge clk);
      if (n - RL >= 0 && n - RL < ne && ek[n - RL]) begin
        int a;
        logic [NP-1:0] exp_w;
        a = n - RL;
        exp_w = model_we(em[a], et[a]);
        tests++;
        if (we_o !== exp_w) begin
          fails++;
          $display("FAIL R3 entry %0d: we_o=%h expected %h", a, we_o, exp_w);
        end
        if (ew_ok[a]) begin
          tests++;
          if (we_o !== ew[a]) begin
            fails++;
            $display("FAIL %s table entry %0d: we_o=%h expected %h", tag_of(em[a]), a, we_o, ew[a]);
          end
        end
      end
      if (n - RL - 1 >= 0 && n - RL - 1 < ne && ek[n - RL - 1]) begin
        int b;
        logic [DW*NP-1:0] exp_d;
        b = n - RL - 1;
        exp_d = model_data(em[b], et[b], ed[b]);
        tests++;
        // R1 R2 R4 R5 packing, latency, idle zero, back-to-back
        if (data_o !== exp_d) begin
          fails++;
          $display("FAIL %s R2 R4 R5 entry %0d: data_o=%h expected %h", tag_of(em[b]), b, data_o, exp_d);
        end
        if (cnt(em[b]) == NP && et[b] == '0) begin
          tests++;
          if (data_o !== ed[b]) begin
            fails++;
            $display("FAIL R6 entry %0d: data_o=%h expected %h", b, data_o, ed[b]);
          end
        end
      end
      if (n < ne) begin
        chan_mask_i = em[n]; slot_i = et[n]; data_i = ed[n];
      end else begin
        chan_mask_i = '0; slot_i = '0; data_i = '0;
      end
    end

    // R2 directed: hold a full-mask config, then switch; data_o keeps the old value for RL cycles
    begin
      logic [DW*NP-1:0] d1, d2;
      d1 = rnd_data(); d2 = rnd_data();
      chan_mask_i = 8'hFF; slot_i = '0; data_i = d1;
      repeat (RL + 3) @(negedge clk);
      chan_mask_i = 8'h10; slot_i = 3'd6; data_i = d2;
      repeat (RL) @(negedge clk);
      tests++;
      if (data_o !== d1) begin
        fails++;
        $display("FAIL R2 hold: data_o=%h expected %h", data_o, d1);
      end
      @(negedge clk);
      tests++;
      if (data_o !== {d2[4*DW +: DW], {(DW*6){1'b0}}, {DW{1'b0}}} >> 0 &&
          data_o !== ({{DW{1'b0}}, d2[4*DW +: DW], {(DW*6){1'b0}}})) begin
        fails++;
        $display("FAIL R7 switch: data_o=%h expected %h", data_o,
                 {{DW{1'b0}}, d2[4*DW +: DW], {(DW*6){1'b0}}});
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule